// File: doc/BRIEF.md
# Glitch-Free Clock Stop Bank

This block sits between a set of free-running clock sources and the clock pins they feed. It holds two byte-wide configuration registers, written and read through a simple byte-address port in a configuration clock domain. Each functional bit of these registers decides whether one output clock runs or is held at logic low. The first register controls five "A" outputs and the reference output. The second controls five "B" outputs. Every register bit comes out of reset set, so every output runs after power-up.

Each of the eleven outputs has its own lane. A lane carries the enable into its own clock domain and passes it through a two-state controller, `LANE_RUNNING` and `LANE_PARKED`. Both the synchronizer flop and the state register are clocked on the falling edge of that lane's source clock. The `STOP` transition goes from `LANE_RUNNING` to `LANE_PARKED` when the synchronized enable is low. The `START` transition goes from `LANE_PARKED` to `LANE_RUNNING` when it is high. The output is the source clock ANDed with the running state. Because the state only changes while the source is low, no high phase is ever cut short, and a restarted output begins on a full rising edge.

Top module: `clkstop_bank`

## Requirements
- R1: After reset, both registers read back 8'hFF and all eleven outputs follow their source clocks.
- R2: A write to address 0 sets the A-bank register. Bits 0 to 4 enable outputs A0 to A4, and bit 5 enables the reference output.
- R3: A write to address 1 sets the B-bank register. Bits 0 to 4 enable outputs B0 to B4.
- R4: An output whose enable is 0 is held at logic low. An output whose enable is 1 is high exactly when its source clock is high.
- R5: The reserved bits (bits 6 and 7 at address 0, bits 5 to 7 at address 1) always read back as 1, and writing them affects no output.
- R6: A change of an enable takes effect on its output within two cycles of that output's source clock after the write.
- R7: Every high pulse on an output has exactly the width of its source clock's high phase, including the last pulse before a stop.
- R8: After a restart, the first output pulse is a full high phase that begins on a rising edge of the source clock.
- R9: A write changes only the addressed register, and the registers hold their values when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for registers and lanes |
| cfg_clk | input | 1 | Configuration clock for register writes |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of cfg_clk |
| reg_addr | input | 1 | Register select: 0 selects the A bank, 1 selects the B bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback of the register selected by reg_addr, with reserved bits set to 1 |
| clk_a_in | input | 5 | Source clocks for the A outputs |
| clk_b_in | input | 5 | Source clocks for the B outputs |
| clk_ref_in | input | 1 | Source clock for the reference output |
| clk_a_out | output | 5 | Gated A clocks |
| clk_b_out | output | 5 | Gated B clocks |
| clk_ref_out | output | 1 | Gated reference clock |

## Verification
The bench measures the width of every high pulse on every output, with eleven unrelated source periods running at once. A lane that changed its gate while the source was high would show up as a short pulse, both when stopping and when restarting. Directed cases toggle each enable alone and sample the output after exactly two source periods, which catches a lane with an extra synchronizer stage or a bit mapped to the wrong output. Writes with all reserved bits cleared, and writes with only reserved bits set, expose a design that stores reserved bits or lets them leak into the reference or B lanes. Random writes then compare readback of both addresses after each write, to catch writes that land in the wrong register.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
    localparam int A_COUNT = 5;
    localparam int B_COUNT = 5;
    localparam int BYTE_W  = 8;

    typedef enum logic {
        LANE_PARKED  = 1'b0,
        LANE_RUNNING = 1'b1
    } lane_state_e;
endpackage

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs #(
    parameter int A_N   = 5,
    parameter int B_N   = 5,
    parameter int REG_W = 8
) (
    input  logic             cfg_clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [A_N-1:0]   en_a,
    output logic             en_ref,
    output logic [B_N-1:0]   en_b
);
    // Reference enable sits just above the A-bank bits.
    localparam int REF_POS = A_N;

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a   <= '1;
            en_ref <= 1'b1;
            en_b   <= '1;
        end else if (wr_en) begin
            if (reg_addr == 1'b0) begin
                en_a   <= wdata[A_N-1:0];
                en_ref <= wdata[REF_POS];
            end else begin
                en_b   <= wdata[B_N-1:0];
            end
        end
    end

    // Reserved positions are not stored and always return 1.
    always_comb begin
        rdata = '1;
        if (reg_addr == 1'b0) begin
            rdata[A_N-1:0] = en_a;
            rdata[REF_POS] = en_ref;
        end else begin
            rdata[B_N-1:0] = en_b;
        end
    end
endmodule

// File: rtl/clkstop_lane.sv
`timescale 1ns/1ps
module clkstop_lane
    import clkstop_pkg::*;
(
    input  logic rst_n,
    input  logic en_req,
    input  logic clk_in,
    output logic run,
    output logic clk_out
);
    logic        en_meta;
    lane_state_e state_q;
    lane_state_e state_d;

    // Both stages sample on the falling edge, so the gate moves only while clk_in is low.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            en_meta <= 1'b1;
            state_q <= LANE_RUNNING;
        end else begin
            en_meta <= en_req;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_RUNNING: if (!en_meta) state_d = LANE_PARKED;   // STOP
            LANE_PARKED:  if (en_meta)  state_d = LANE_RUNNING;  // START
            default:      state_d = LANE_RUNNING;
        endcase
    end

    always_comb begin
        run     = (state_q == LANE_RUNNING);
        clk_out = clk_in & run;
    end
endmodule

// File: rtl/clkstop_bank.sv
`timescale 1ns/1ps
module clkstop_bank
    import clkstop_pkg::*;
#(
    parameter int A_N   = A_COUNT,
    parameter int B_N   = B_COUNT,
    parameter int REG_W = BYTE_W
) (
    input  logic             rst_n,
    input  logic             cfg_clk,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [A_N-1:0]   clk_a_in,
    input  logic [B_N-1:0]   clk_b_in,
    input  logic             clk_ref_in,
    output logic [A_N-1:0]   clk_a_out,
    output logic [B_N-1:0]   clk_b_out,
    output logic             clk_ref_out
);
    localparam int N_LANES = A_N + B_N + 1;

    logic [A_N-1:0]     en_a;
    logic [B_N-1:0]     en_b;
    logic               en_ref;
    logic [N_LANES-1:0] lane_en;
    logic [N_LANES-1:0] lane_clk;
    logic [N_LANES-1:0] lane_out;
    logic [N_LANES-1:0] lane_run;

    clkstop_regs #(.A_N(A_N), .B_N(B_N), .REG_W(REG_W)) u_regs (
        .cfg_clk  (cfg_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .en_a     (en_a),
        .en_ref   (en_ref),
        .en_b     (en_b)
    );

    // Lane order: A outputs, then B outputs, then the reference.
    assign lane_en  = {en_ref, en_b, en_a};
    assign lane_clk = {clk_ref_in, clk_b_in, clk_a_in};

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        clkstop_lane u_lane (
            .rst_n   (rst_n),
            .en_req  (lane_en[i]),
            .clk_in  (lane_clk[i]),
            .run     (lane_run[i]),
            .clk_out (lane_out[i])
        );
    end

    assign clk_a_out   = lane_out[A_N-1:0];
    assign clk_b_out   = lane_out[A_N+B_N-1:A_N];
    assign clk_ref_out = lane_out[N_LANES-1];
endmodule

// File: rtl/clkstop_bank_chk.sv
`timescale 1ns/1ps
module clkstop_bank_chk #(
    parameter int A_N   = 5,
    parameter int B_N   = 5,
    parameter int REG_W = 8
) (
    input logic                 cfg_clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 reg_addr,
    input logic [REG_W-1:0]     wdata,
    input logic [REG_W-1:0]     rdata,
    input logic [A_N-1:0]       en_a,
    input logic                 en_ref,
    input logic [B_N-1:0]       en_b,
    input logic [A_N+B_N:0]     lane_en,
    input logic [A_N+B_N:0]     lane_clk,
    input logic [A_N+B_N:0]     lane_run,
    input logic [A_N+B_N:0]     lane_out
);
    localparam int N_LANES = A_N + B_N + 1;

    p_wr_a_r2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && reg_addr == 1'b0) |=>
            (en_a == $past(wdata[A_N-1:0]) && en_ref == $past(wdata[A_N]) && $stable(en_b)));

    p_wr_b_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && reg_addr == 1'b1) |=>
            (en_b == $past(wdata[B_N-1:0]) && $stable(en_a) && $stable(en_ref)));

    p_hold_r9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !wr_en |=> ($stable(en_a) && $stable(en_b) && $stable(en_ref)));

    p_rsvd_a_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (&rdata[REG_W-1:A_N+1]));

    p_rsvd_b_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (reg_addr == 1'b1) |-> (&rdata[REG_W-1:B_N]));

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane_chk
        p_park_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
            !lane_run[g] |-> !lane_out[g]);

        // An enable held over two falling edges must be reflected by the lane state.
        p_follow_r6: assert property (@(negedge lane_clk[g]) disable iff (!rst_n)
            (lane_en[g] == $past(lane_en[g]) && lane_en[g] == $past(lane_en[g], 2))
                |-> (lane_run[g] == lane_en[g]));
    end
endmodule

bind clkstop_bank clkstop_bank_chk #(.A_N(A_N), .B_N(B_N), .REG_W(REG_W)) u_chk (
    .cfg_clk  (cfg_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .en_a     (en_a),
    .en_ref   (en_ref),
    .en_b     (en_b),
    .lane_en  (lane_en),
    .lane_clk (lane_clk),
    .lane_run (lane_run),
    .lane_out (lane_out)
);

// File: tb/tb_clkstop_bank.sv
`timescale 1ns/1ps
module tb_clkstop_bank;
    localparam int NL = 11;

    logic       rst_n;
    logic       cfg_clk;
    logic       wr_en;
    logic       reg_addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       lclk [NL];
    logic [NL-1:0] lin;
    logic [NL-1:0] lout;
    logic [4:0] a_out, b_out;
    logic       ref_out;

    int n_cmp  = 0;
    int n_fail = 0;
    bit mon_on = 0;
    bit done   = 0;

    logic [5:0] m_a;
    logic [4:0] m_b;

    clkstop_bank dut (
        .rst_n(rst_n), .cfg_clk(cfg_clk), .wr_en(wr_en), .reg_addr(reg_addr),
        .wdata(wdata), .rdata(rdata),
        .clk_a_in(lin[4:0]), .clk_b_in(lin[9:5]), .clk_ref_in(lin[10]),
        .clk_a_out(a_out), .clk_b_out(b_out), .clk_ref_out(ref_out)
    );
    assign lout = {ref_out, b_out, a_out};

    initial begin
        cfg_clk = 0;
        forever #2 cfg_clk = ~cfg_clk;
    end

    function automatic int half_of(int i);
        return 3 + i;
    endfunction

    for (genvar g = 0; g < NL; g++) begin : g_src
        initial begin
            lclk[g] = 0;
            forever #(3 + g) lclk[g] = ~lclk[g];
        end
        assign lin[g] = lclk[g];
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R7 / R8: every output high pulse must equal its source high phase.
    for (genvar g = 0; g < NL; g++) begin : g_mon
        realtime t_up = -1.0;
        always @(posedge lout[g]) t_up = $realtime;
        always @(negedge lout[g]) begin
            if (mon_on && t_up >= 0.0)
                chk(($realtime - t_up) == half_of(g), "R7/R8 pulse width",
                    int'($realtime - t_up), half_of(g));
        end
    end

    function automatic bit exp_lane(int i);
        if (i < 5)  return m_a[i];
        if (i < 10) return m_b[i-5];
        return m_a[5];
    endfunction

    function automatic logic [7:0] exp_rd(bit adr);
        return adr ? {3'b111, m_b} : {2'b11, m_a};
    endfunction

    task automatic do_write(bit adr, logic [7:0] d);
        @(negedge cfg_clk);
        wr_en = 1; reg_addr = adr; wdata = d;
        @(posedge cfg_clk);
        #1;
        wr_en = 0;
        if (adr) m_b = d[4:0];
        else     m_a = d[5:0];
    endtask

    task automatic check_read(bit adr, string req);
        @(negedge cfg_clk);
        reg_addr = adr;
        #1;
        chk(rdata == exp_rd(adr), req, rdata, exp_rd(adr));
    endtask

    task automatic check_lane(int i, string req);
        @(posedge lin[i]);
        #1;
        chk(lout[i] == exp_lane(i), req, lout[i], exp_lane(i));
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < NL; i++) check_lane(i, req);
    endtask

    initial begin
        rst_n = 0; wr_en = 0; reg_addr = 0; wdata = 0;
        m_a = '1; m_b = '1;
        void'($urandom(32'h5EED_C10C));
        #25;
        rst_n = 1;
        mon_on = 1;
        #60;
        // R1: reset state
        check_read(0, "R1 reset A");
        check_read(1, "R1 reset B");
        check_all("R1 all running");

        // R6 / R2 / R3 / R4: each lane alone, stop then restart, sampled after two source periods
        for (int i = 0; i < NL; i++) begin
            bit adr = (i >= 5 && i < 10);
            int bitp = (i < 5) ? i : ((i < 10) ? i - 5 : 5);
            logic [7:0] d = adr ? {3'b000, m_b} : {2'b00, m_a};
            d[bitp] = 1'b0;
            do_write(adr, d);
            #(4 * half_of(i));
            check_lane(i, "R6 stop latency R4 parked");
            d[bitp] = 1'b1;
            do_write(adr, d);
            #(4 * half_of(i));
            check_lane(i, "R6 start latency R4 running");
        end

        // R2: A bank pattern, reference parked
        do_write(0, 8'h15);
        #60;
        check_read(1, "R9 B untouched");
        check_all("R2 A bank map");
        // R3: B bank pattern
        do_write(1, 8'h0A);
        #60;
        check_read(0, "R9 A untouched");
        check_all("R3 B bank map");

        // R5: reserved bits cleared and only-reserved writes
        do_write(0, 8'h3F);
        do_write(1, 8'h1F);
        check_read(0, "R5 reserved A reads 1");
        check_read(1, "R5 reserved B reads 1");
        #60;
        check_all("R5 reserved clear no effect");
        do_write(0, 8'hC0);
        do_write(1, 8'hE0);
        check_read(0, "R5 only reserved A");
        check_read(1, "R5 only reserved B");
        #60;
        check_all("R5 only reserved set all parked");

        // Random writes
        for (int k = 0; k < 40; k++) begin
            bit adr = 1'($urandom % 2);
            logic [7:0] d = 8'($urandom % 256);
            do_write(adr, d);
            check_read(0, "R9 random readback A");
            check_read(1, "R9 random readback B");
            #60;
            check_all("R4 random gating");
        end

        // Restore all and confirm
        do_write(0, 8'hFF);
        do_write(1, 8'hFF);
        #60;
        check_all("R8 restart all");
        #100;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule